// File: doc/BRIEF.md
# Mode-Selectable Registered Bus Transceiver

This block is a 9-bit, two-way bus transceiver. One side is a push-pull port, called side A. The other side is an open-collector backplane port, called side B. Each direction has its own storage stage and its own capture control. A shared 2-bit mode code decides whether each direction passes its input straight through, holds it in a level-sensitive latch, or captures it into an edge-triggered register. One code mixes the two storage kinds: the A-to-B direction uses the register and the B-to-A direction uses the latch.

Side B is driven as one pull-low request per bit. A bit pulls the wire low when its internal data is 1 and leaves the wire released otherwise. The received wire level comes back through a separate input. Data that reaches side A is the inverse of the level received on side B. Side A signals "high impedance" through its own drive-enable output instead of a tri-state net. Side B drives only when its two enables agree: the active-high enable is 1 and the active-low enable is 0. A power-good input turns both ports off.

The capture controls are ordinary inputs sampled on the system clock. A control edge therefore means a sampled low followed by a sampled high. Latch transparency is combinational while the control is low.

Top module: `regbus_xcvr`

## Requirements
- R1: Mode code 2'b01 routes the current `a_in` to side B and the current `b_in` to side A with no storage, in both directions.
- R2: Mode code 2'b00 uses the latch in both directions. While the capture control is 0, the input passes through. While it is 1, the output holds the input sampled at the last clock edge at which the control was 0.
- R3: Mode code 2'b10 uses the register in both directions. A direction captures its input at a clock edge where its control is 1 and was 0 at the previous edge, and the new value shows after that edge. A control that is already 1 when reset releases is not an edge.
- R4: Mode code 2'b11 uses the register for A-to-B (control `cap_a`) and the latch for B-to-A (control `cap_b`).
- R5: Bit i of `b_pull` is 1, meaning the wire is pulled low, exactly when the A-to-B data bit is 1 and side B is enabled. `a_out` is the bitwise inverse of the B-to-A data.
- R6: `b_pull` is all zero unless `b_en_hi` is 1 and `b_en_lo_n` is 0.
- R7: `a_drive` equals `a_oe` while power is good. While `a_drive` is 0, `a_out` is all zero.
- R8: While `pwr_good` is 0, `a_drive` is 0 and `b_pull` is all zero, whatever the enables are.
- R9: A synchronous active-low reset clears every latch and register to 0. While reset is held, `b_pull` is 0 and `a_out` is all ones when side A is enabled.
- R10: Changing the enables or power-good leaves the stored values unchanged; re-enabling a port shows the value held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply good; 0 turns both ports off |
| mode_sel | input | 2 | Storage mode code for both directions |
| cap_a | input | 1 | Capture control, A-to-B direction |
| cap_b | input | 1 | Capture control, B-to-A direction |
| a_oe | input | 1 | Side A output enable, active high |
| b_en_hi | input | 1 | Side B enable, active high |
| b_en_lo_n | input | 1 | Side B enable, active low |
| a_in | input | 9 | Data received on side A |
| b_in | input | 9 | Wire levels received on side B |
| a_out | output | 9 | Data driven on side A (inverse of B-to-A data) |
| a_drive | output | 1 | Side A actually driving; 0 means high impedance |
| b_pull | output | 9 | Per-bit pull-low request on side B |

## Verification
The embedded properties check the port gating on every cycle: the B-enable pair, the A enable and the power-good override. They also check the storage stages: a latch holds steady while its control stays high, and a register stays still when no control edge was sampled. Only the bench's scenarios can show the actual values captured. These include which input value a latch holds, what the register takes at a rising control edge, the mixed mode code, the inversion across side B, and the stored values surviving a disable and re-enable.

// File: rtl/regbus_xcvr_pkg.sv
// Shared types for the registered bus transceiver.
// Assumes the 2-bit mode code values below are fixed by the bus protocol.
package regbus_xcvr_pkg;

    // Mode code as presented on mode_sel.
    typedef enum logic [1:0] {
        SEL_LATCH = 2'b00,
        SEL_THRU  = 2'b01,
        SEL_FLOP  = 2'b10,
        SEL_MIXED = 2'b11
    } sel_code_e;

    // Storage choice of a single direction.
    typedef enum logic [1:0] {
        PATH_LATCH = 2'b00,
        PATH_THRU  = 2'b01,
        PATH_FLOP  = 2'b10
    } path_mode_e;

endpackage

// File: rtl/regbus_mode_decode.sv
// Turns the shared mode code into the storage choice of one direction.
// MIXED_FLOP selects what the mixed code means for this direction:
// 1 gives the register, 0 gives the latch. Pure combinational logic.
module regbus_mode_decode
    import regbus_xcvr_pkg::*;
#(
    parameter bit MIXED_FLOP = 1'b1
) (
    input  logic [1:0] sel,
    output path_mode_e mode
);

    localparam path_mode_e MIXED_MODE = MIXED_FLOP ? PATH_FLOP : PATH_LATCH;

    // Map each code value to this direction's storage choice.
    always_comb begin
        case (sel_code_e'(sel))
            SEL_LATCH: mode = PATH_LATCH;
            SEL_THRU:  mode = PATH_THRU;
            SEL_FLOP:  mode = PATH_FLOP;
            default:   mode = MIXED_MODE;
        endcase
    end

endmodule

// File: rtl/regbus_path_store.sv
// Storage stage of one direction: a bypass, a level latch and an edge register.
// The latch is transparent while ctl is 0 and otherwise holds the input it
// sampled at the last clock edge with ctl low. The register captures at a
// clock edge where ctl is 1 after a 0. Assumes ctl is synchronous to clk.
module regbus_path_store
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  path_mode_e       mode,
    input  logic             ctl,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] held_q;
    logic [WIDTH-1:0] flop_q;
    logic             ctl_q;
    logic             ctl_rise;

    assign ctl_rise = ctl & ~ctl_q;

    // Latch store, edge register and control history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
            flop_q <= '0;
            ctl_q  <= 1'b1;
        end else begin
            if (!ctl) begin
                held_q <= din;
            end
            if (ctl_rise) begin
                flop_q <= din;
            end
            ctl_q <= ctl;
        end
    end

    // Output selection according to the decoded mode.
    always_comb begin
        case (mode)
            PATH_LATCH: dout = ctl ? held_q : din;
            PATH_FLOP:  dout = flop_q;
            default:    dout = din;
        endcase
    end

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PATH_LATCH && ctl && $past(mode == PATH_LATCH) && $past(ctl) && $past(rst_n))
        |-> $stable(dout));

    // R3
    flop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PATH_FLOP && $past(mode == PATH_FLOP) && !$past(ctl) && $past(rst_n))
        |-> $stable(dout));

endmodule

// File: rtl/regbus_xcvr.sv
// Top of the registered bus transceiver. It holds one storage stage per
// direction and gates both ports. Side B is open collector: b_pull[i]=1 pulls
// the wire low. Side A reports high impedance through a_drive.
// Assumes b_in carries the resolved wire levels of side B.
module regbus_xcvr
    import regbus_xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_good,
    input  logic [1:0]       mode_sel,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic             a_oe,
    input  logic             b_en_hi,
    input  logic             b_en_lo_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive,
    output logic [WIDTH-1:0] b_pull
);

    localparam int NDIR = 2;

    path_mode_e       dir_mode [NDIR];
    logic             dir_ctl  [NDIR];
    logic [WIDTH-1:0] dir_in   [NDIR];
    logic [WIDTH-1:0] dir_out  [NDIR];
    logic             b_drive;

    assign dir_ctl[0] = cap_a;
    assign dir_ctl[1] = cap_b;
    assign dir_in[0]  = a_in;
    assign dir_in[1]  = b_in;

    // Index 0 carries A-to-B data, index 1 carries B-to-A data.
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        regbus_mode_decode #(
            .MIXED_FLOP (d == 0)
        ) u_dec (
            .sel  (mode_sel),
            .mode (dir_mode[d])
        );

        regbus_path_store #(
            .WIDTH (WIDTH)
        ) u_store (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (dir_mode[d]),
            .ctl   (dir_ctl[d]),
            .din   (dir_in[d]),
            .dout  (dir_out[d])
        );
    end

    // Port gating: side B needs both enables in agreement and good power.
    always_comb begin
        b_drive = pwr_good & b_en_hi & ~b_en_lo_n;
        a_drive = pwr_good & a_oe;
        b_pull  = b_drive ? dir_out[0] : '0;
        a_out   = a_drive ? ~dir_out[1] : '0;
    end

    // R6
    b_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|b_pull) |-> (b_en_hi && !b_en_lo_n));

    // R8
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |-> (!a_drive && b_pull == '0));

    // R7
    a_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_drive |-> (a_out == '0));

    // R7
    a_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        a_drive |-> a_oe);

endmodule

// File: tb/regbus_xcvr_bench.sv
`timescale 1ns/1ps
module regbus_xcvr_bench;

    localparam int W = 9;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_good = 1'b1;
    logic [1:0]   mode_sel = 2'b10;
    logic         cap_a = 1'b1;
    logic         cap_b = 1'b1;
    logic         a_oe = 1'b1;
    logic         b_en_hi = 1'b1;
    logic         b_en_lo_n = 1'b0;
    logic [W-1:0] a_in = 9'h055;
    logic [W-1:0] b_in = 9'h0AA;
    logic [W-1:0] a_out;
    logic         a_drive;
    logic [W-1:0] b_pull;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    regbus_xcvr #(.WIDTH(W)) u_regbus_xcvr (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .mode_sel(mode_sel),
        .cap_a(cap_a), .cap_b(cap_b), .a_oe(a_oe), .b_en_hi(b_en_hi),
        .b_en_lo_n(b_en_lo_n), .a_in(a_in), .b_in(b_in), .a_out(a_out),
        .a_drive(a_drive), .b_pull(b_pull)
    );

    // Fields: sel, cap_a, cap_b, a_in, b_in, expected b_pull, expected a_out
    localparam logic [39:0] VECS [0:11] = '{
        {2'b01, 1'b0, 1'b0, 9'h0A5, 9'h13C, 9'h0A5, 9'h0C3}, // R1 bypass
        {2'b00, 1'b0, 1'b0, 9'h155, 9'h0F0, 9'h155, 9'h10F}, // R2 transparent
        {2'b00, 1'b1, 1'b1, 9'h1FF, 9'h000, 9'h155, 9'h10F}, // R2 hold
        {2'b00, 1'b1, 1'b1, 9'h001, 9'h1FE, 9'h155, 9'h10F}, // R2 hold
        {2'b10, 1'b1, 1'b1, 9'h0AA, 9'h011, 9'h1FF, 9'h1FF}, // R3 earlier edge
        {2'b10, 1'b0, 1'b0, 9'h033, 9'h0CC, 9'h1FF, 9'h1FF}, // R3 no edge
        {2'b10, 1'b1, 1'b1, 9'h12D, 9'h0B4, 9'h12D, 9'h14B}, // R3 edge, R5
        {2'b11, 1'b0, 1'b0, 9'h0F0, 9'h1E1, 9'h12D, 9'h01E}, // R4 mixed
        {2'b11, 1'b1, 1'b1, 9'h00F, 9'h1C3, 9'h00F, 9'h01E}, // R4 mixed
        {2'b11, 1'b1, 1'b0, 9'h100, 9'h066, 9'h00F, 9'h199}, // R4 mixed
        {2'b10, 1'b1, 1'b1, 9'h1AB, 9'h077, 9'h00F, 9'h188}, // R3 one edge
        {2'b00, 1'b1, 1'b1, 9'h1AB, 9'h077, 9'h0F0, 9'h199}  // R2 old hold
    };

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        // R9: reset state with the register mode selected
        repeat (3) step();
        check("R9", "b_pull in reset", b_pull, 9'h000);
        check("R9", "a_out in reset", a_out, 9'h1FF);
        check("R9", "a_drive in reset", {8'h00, a_drive}, 9'h001);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R3", "no edge at reset release b", b_pull, 9'h000);
        check("R3", "no edge at reset release a", a_out, 9'h1FF);

        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            {mode_sel, cap_a, cap_b, a_in, b_in} = VECS[i][39:18];
            step();
            check("R1-5vec", $sformatf("vec%0d b_pull", i), b_pull, VECS[i][17:9]);
            check("R1-5vec", $sformatf("vec%0d a_out", i), a_out, VECS[i][8:0]);
        end

        // R6: enable pair
        @(negedge clk); b_en_hi = 1'b0; step();
        check("R6", "b off by high enable", b_pull, 9'h000);
        check("R6", "a unaffected", a_out, 9'h199);
        @(negedge clk); b_en_hi = 1'b1; b_en_lo_n = 1'b1; step();
        check("R6", "b off by low enable", b_pull, 9'h000);
        @(negedge clk); b_en_lo_n = 1'b0; step();
        check("R10", "b latch kept", b_pull, 9'h0F0);
        // R7: side A enable
        @(negedge clk); a_oe = 1'b0; step();
        check("R7", "a_drive low", {8'h00, a_drive}, 9'h000);
        check("R7", "a_out quiet", a_out, 9'h000);
        @(negedge clk); a_oe = 1'b1; step();
        check("R10", "a latch kept", a_out, 9'h199);
        // R8: power-good
        @(negedge clk); pwr_good = 1'b0; step();
        check("R8", "a off", {8'h00, a_drive}, 9'h000);
        check("R8", "b off", b_pull, 9'h000);
        @(negedge clk); pwr_good = 1'b1; mode_sel = 2'b10; step();
        check("R10", "b flop kept", b_pull, 9'h00F);
        check("R5", "a flop inverted", a_out, 9'h188);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule